// File: doc/BRIEF.md
# Multiplexed Bus Read-Cycle Sequencer

This block is a host-side master that runs single read cycles on a shared address/data bus. The bus uses an address latch enable, an active-low chip select, an active-low data strobe and a direction line. A read request carries a small register address. The sequencer places that address on the shared lines and latches it into the target with the latch enable. It then releases the lines, pulls the strobe low, captures the returned word as the strobe rises, and reports the word with a one-cycle done pulse.

Every bus timing figure is a parameter in nanoseconds. Each one becomes a count of system clock cycles, rounded up, with at least one cycle per phase. The sequencer also keeps track of earlier strobes so that the target's pacing rules hold. Consecutive strobe falling edges stay at least four arbitration periods apart. A read of either address-pointer register that comes right after a data-register access waits a longer recovery gap, measured from the previous trailing edge. The arbitration period is the target's operating period, or twice that period while `slow_arb` is high. Only one cycle is in flight at a time, and a ready/valid handshake holds off new requests.

Top module: `mbus_rd_seq`

## Requirements
- R1: While reset is asserted and right after it, the outputs are idle: `bus_cs_n`=1, `bus_ds_n`=1, `bus_ale`=0, `bus_ad_oe`=0, `bus_dir`=0, `rsp_valid`=0, and `req_ready`=1.
- R2: `req_ready` is high only while no cycle is in progress. A request is taken in a cycle where `req_valid` and `req_ready` are both high. While a cycle runs, `req_ready` stays low.
- R3: Starting in the cycle after a request is taken, `bus_ale` is high for ceil(max(address setup 20 ns, latch-enable width 20 ns, select setup 10 ns) / Tclk) cycles, which is 5 at the defaults. During those cycles `bus_cs_n` is 0, `bus_ad_oe` is 1 and `bus_ad_o` carries the request address, zero-extended.
- R4: After `bus_ale` falls, the address stays driven for ceil(10 ns / Tclk) cycles (3) before `bus_ad_oe` drops. The strobe falls no earlier than ceil(15 ns / Tclk) cycles (4) after the latch enable falls. `bus_ad_oe` is never high while the strobe is low.
- R5: The strobe stays low for ceil(max(60 ns, 40 ns data-valid) / Tclk) cycles (15). `bus_ad_i` is captured at the clock edge where the strobe returns high. `rsp_valid` is high for exactly one cycle, which is the first cycle with the strobe high again, and `rsp_data` holds the captured word.
- R6: `bus_dir` is 1 (read) from the address phase until ceil(10 ns / Tclk) cycles (3) after the strobe rises, so it leads the strobe by at least 3 cycles. `bus_cs_n` is 0 whenever the strobe is low.
- R7: Consecutive strobe falling edges are at least ceil(4·Tarb / Tclk) cycles apart. Tarb is the operating period (25 ns by default) when `slow_arb`=0 and twice it when `slow_arb`=1. That gives 25 or 50 cycles.
- R8: A read of address 2 or 3 (the pointer registers) whose previous strobe addressed register 4 (the data register) begins its strobe at least ceil(5·Tarb / Tclk) cycles after that previous strobe rose. That is 32 cycles when `slow_arb`=0 and 63 when `slow_arb`=1.
- R9: The sequencer adds no wait beyond the largest applicable rule. With requests offered as soon as `req_ready` rises, falling edges are 28 cycles apart unless R7 or R8 demands more, in which case the gap equals that demand. When no history rule applies, the strobe falls 10 cycles after the request is taken.
- R10: Reset aborts a cycle in progress and clears the strobe history. The first access after reset waits on no earlier strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_arb | input | 1 | 1 = arbitration period is twice the operating period |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | AW | Register address to read |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_data | output | DW | Captured read word |
| bus_ad_o | output | DW | Value driven on the shared lines |
| bus_ad_oe | output | 1 | Master drives the shared lines |
| bus_ad_i | input | DW | Value seen on the shared lines |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_dir | output | 1 | Direction, 1 = read |

## Verification
A table of back-to-back reads is run in an order that sets the spacing rules against each other. These include data-then-pointer pairs at both arbitration speeds, pointer-then-pointer pairs, data-then-plain-register pairs, and slow-speed pairs without a pointer. Each measured gap between falling edges therefore shows which rule governs: the natural cycle length, the four-period rule, or the longer pointer recovery. A modelled target returns its word only 10 cycles into the strobe and returns the inverted word before that, so an early capture shows up as a wrong word. A reset in the middle of a strobe, followed by a pointer read, separates history that was cleared from history that was kept.

// File: rtl/mbus_rd_pkg.sv
package mbus_rd_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_ADDR    = 3'd1,
    SQ_HOLD    = 3'd2,
    SQ_WAIT    = 3'd3,
    SQ_STROBE  = 3'd4,
    SQ_RECOVER = 3'd5
  } seq_state_t;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mbus_phase_timer.sv
module mbus_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          last
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/mbus_gap_tracker.sv
module mbus_gap_tracker #(
  parameter int N_CYC_F = 25,
  parameter int N_CYC_S = 50,
  parameter int N_PTR_F = 32,
  parameter int N_PTR_S = 63,
  parameter int N_DSH   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ds_n,
  input  logic slow_arb,
  input  logic cur_ptr,
  input  logic cur_data,
  output logic gap_ok
);
  import mbus_rd_pkg::*;

  localparam int GMAX = imax(imax(N_CYC_S, N_PTR_S), imax(imax(N_CYC_F, N_PTR_F), N_DSH));
  localparam int GW   = $clog2(GMAX + 1);
  localparam logic [GW-1:0] SAT     = GW'(GMAX);
  localparam logic [GW-1:0] TH_CYCF = GW'(N_CYC_F - 1);
  localparam logic [GW-1:0] TH_CYCS = GW'(N_CYC_S - 1);
  localparam logic [GW-1:0] TH_PTRF = GW'(N_PTR_F - 1);
  localparam logic [GW-1:0] TH_PTRS = GW'(N_PTR_S - 1);
  localparam logic [GW-1:0] TH_DSH  = GW'(N_DSH - 1);

  logic          prev_ds_q;
  logic [GW-1:0] since_fall_q, since_fall_d;
  logic [GW-1:0] since_rise_q, since_rise_d;
  logic          last_data_q, last_data_d;
  logic          fell, rose;
  logic [GW-1:0] th_cyc, th_ptr;
  logic          cyc_ok, high_ok, ptr_ok;

  assign fell = !ds_n && prev_ds_q;
  assign rose = ds_n && !prev_ds_q;

  always_comb begin
    since_fall_d = since_fall_q;
    since_rise_d = since_rise_q;
    last_data_d  = last_data_q;
    if (fell) begin
      since_fall_d = GW'(1);
      last_data_d  = cur_data;
    end else if (since_fall_q != SAT) begin
      since_fall_d = since_fall_q + GW'(1);
    end
    if (rose) begin
      since_rise_d = GW'(1);
    end else if (since_rise_q != SAT) begin
      since_rise_d = since_rise_q + GW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ds_q    <= 1'b1;
      since_fall_q <= SAT;
      since_rise_q <= SAT;
      last_data_q  <= 1'b0;
    end else begin
      prev_ds_q    <= ds_n;
      since_fall_q <= since_fall_d;
      since_rise_q <= since_rise_d;
      last_data_q  <= last_data_d;
    end
  end

  // The decision is made one cycle before the strobe would fall, hence N-1.
  assign th_cyc  = slow_arb ? TH_CYCS : TH_CYCF;
  assign th_ptr  = slow_arb ? TH_PTRS : TH_PTRF;
  assign cyc_ok  = since_fall_q >= th_cyc;
  assign high_ok = since_rise_q >= TH_DSH;
  assign ptr_ok  = !(cur_ptr && last_data_q) || (since_rise_q >= th_ptr);
  assign gap_ok  = cyc_ok && high_ok && ptr_ok;

endmodule

// File: rtl/mbus_rd_fsm.sv
module mbus_rd_fsm #(
  parameter int AW      = 3,
  parameter int CW      = 5,
  parameter int N_ADDR  = 5,
  parameter int N_AFTER = 4,
  parameter int N_OE    = 3,
  parameter int N_DSL   = 15,
  parameter int N_REC   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  input  logic          gap_ok,
  input  logic          tmr_last,
  input  logic [CW-1:0] tmr_cnt,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic [AW-1:0] addr,
  output logic          ale,
  output logic          cs_n,
  output logic          ds_n,
  output logic          dir,
  output logic          oe,
  output logic          cap_en
);
  import mbus_rd_pkg::*;

  localparam logic [CW-1:0] OE_OFF = CW'(N_AFTER - N_OE);

  seq_state_t    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          accept;

  assign accept = (state_q == SQ_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      SQ_IDLE: begin
        if (req_valid) begin
          state_d  = SQ_ADDR;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_ADDR);
        end
      end
      SQ_ADDR: begin
        if (tmr_last) begin
          state_d  = SQ_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_AFTER);
        end
      end
      SQ_HOLD: begin
        if (tmr_last) begin
          if (gap_ok) begin
            state_d  = SQ_STROBE;
            tmr_load = 1'b1;
            tmr_val  = CW'(N_DSL);
          end else begin
            state_d = SQ_WAIT;
          end
        end
      end
      SQ_WAIT: begin
        if (gap_ok) begin
          state_d  = SQ_STROBE;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_DSL);
        end
      end
      SQ_STROBE: begin
        if (tmr_last) begin
          state_d  = SQ_RECOVER;
          tmr_load = 1'b1;
          tmr_val  = CW'(N_REC);
        end
      end
      SQ_RECOVER: begin
        if (tmr_last) begin
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    addr_d = addr_q;
    if (accept) begin
      addr_d = req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
    end
  end

  assign req_ready = (state_q == SQ_IDLE);
  assign addr      = addr_q;
  assign ale       = (state_q == SQ_ADDR);
  assign cs_n      = (state_q == SQ_IDLE);
  assign ds_n      = (state_q != SQ_STROBE);
  assign dir       = (state_q != SQ_IDLE);
  assign oe        = (state_q == SQ_ADDR) || ((state_q == SQ_HOLD) && (tmr_cnt > OE_OFF));
  assign cap_en    = (state_q == SQ_STROBE) && tmr_last;

endmodule

// File: rtl/mbus_rd_seq.sv
module mbus_rd_seq #(
  parameter int AW          = 3,
  parameter int DW          = 16,
  parameter int CLK_NS      = 4,
  parameter int OPR_NS      = 25,
  parameter int T_ADDR_SU   = 20,
  parameter int T_ADDR_HD   = 10,
  parameter int T_SEL_SU    = 10,
  parameter int T_ALE_HI    = 20,
  parameter int T_ALE_TO_DS = 15,
  parameter int T_DS_LO     = 60,
  parameter int T_DATA_VLD  = 40,
  parameter int T_DS_HI     = 20,
  parameter int T_DIR_SU    = 10,
  parameter int T_DIR_HD    = 10,
  parameter int ARB_CYC_MUL = 4,
  parameter int PTR_GAP_MUL = 5,
  parameter int DATA_REG    = 4,
  parameter int PTR_REG_A   = 2,
  parameter int PTR_REG_B   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_arb,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_i,
  output logic          bus_ale,
  output logic          bus_cs_n,
  output logic          bus_ds_n,
  output logic          bus_dir
);
  import mbus_rd_pkg::*;

  localparam int N_ADDR  = imax(imax(ns2cyc(T_ADDR_SU, CLK_NS), ns2cyc(T_ALE_HI, CLK_NS)),
                                ns2cyc(T_SEL_SU, CLK_NS));
  localparam int N_OE    = ns2cyc(T_ADDR_HD, CLK_NS);
  localparam int N_DIRX  = imax(ns2cyc(T_DIR_SU, CLK_NS) - N_ADDR, 1);
  localparam int N_AFTER = imax(imax(N_OE, ns2cyc(T_ALE_TO_DS, CLK_NS)), N_DIRX);
  localparam int N_DSL   = imax(ns2cyc(T_DS_LO, CLK_NS), ns2cyc(T_DATA_VLD, CLK_NS));
  localparam int N_REC   = ns2cyc(T_DIR_HD, CLK_NS);
  localparam int N_DSH   = ns2cyc(T_DS_HI, CLK_NS);
  localparam int N_CYC_F = ns2cyc(ARB_CYC_MUL * OPR_NS, CLK_NS);
  localparam int N_CYC_S = ns2cyc(2 * ARB_CYC_MUL * OPR_NS, CLK_NS);
  localparam int N_PTR_F = ns2cyc(PTR_GAP_MUL * OPR_NS, CLK_NS);
  localparam int N_PTR_S = ns2cyc(2 * PTR_GAP_MUL * OPR_NS, CLK_NS);
  localparam int NMAX    = imax(imax(N_ADDR, N_AFTER), imax(N_DSL, N_REC));
  localparam int CW      = $clog2(NMAX + 1);

  logic          tmr_load, tmr_last, gap_ok, cap_en, oe;
  logic [CW-1:0] tmr_val, tmr_cnt;
  logic [AW-1:0] addr_q;
  logic          cur_ptr, cur_data;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rvld_q;

  mbus_rd_fsm #(
    .AW(AW), .CW(CW), .N_ADDR(N_ADDR), .N_AFTER(N_AFTER),
    .N_OE(N_OE), .N_DSL(N_DSL), .N_REC(N_REC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_ready (req_ready),
    .gap_ok    (gap_ok),
    .tmr_last  (tmr_last),
    .tmr_cnt   (tmr_cnt),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .addr      (addr_q),
    .ale       (bus_ale),
    .cs_n      (bus_cs_n),
    .ds_n      (bus_ds_n),
    .dir       (bus_dir),
    .oe        (oe),
    .cap_en    (cap_en)
  );

  mbus_phase_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .last     (tmr_last)
  );

  assign cur_ptr  = (addr_q == AW'(PTR_REG_A)) || (addr_q == AW'(PTR_REG_B));
  assign cur_data = (addr_q == AW'(DATA_REG));

  mbus_gap_tracker #(
    .N_CYC_F(N_CYC_F), .N_CYC_S(N_CYC_S), .N_PTR_F(N_PTR_F),
    .N_PTR_S(N_PTR_S), .N_DSH(N_DSH)
  ) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .ds_n     (bus_ds_n),
    .slow_arb (slow_arb),
    .cur_ptr  (cur_ptr),
    .cur_data (cur_data),
    .gap_ok   (gap_ok)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (cap_en) begin
      rdata_d = bus_ad_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      rvld_q  <= cap_en;
    end
  end

  assign rsp_valid = rvld_q;
  assign rsp_data  = rdata_q;
  assign bus_ad_oe = oe;
  assign bus_ad_o  = oe ? DW'(addr_q) : '0;

endmodule

// File: rtl/mbus_rd_seq_chk.sv
module mbus_rd_seq_chk #(
  parameter int AW      = 3,
  parameter int DW      = 16,
  parameter int MIN_DSL = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [DW-1:0] bus_ad_o,
  input logic          bus_ad_oe,
  input logic          bus_ale,
  input logic          bus_cs_n,
  input logic          bus_ds_n,
  input logic          bus_dir
);

  localparam int LW = $clog2(MIN_DSL + 2);

  logic [LW-1:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run_q <= '0;
    end else if (bus_ds_n) begin
      low_run_q <= '0;
    end else if (low_run_q != LW'(MIN_DSL + 1)) begin
      low_run_q <= low_run_q + LW'(1);
    end
  end

  a_r6_sel_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> !bus_cs_n);
  a_r6_dir_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> bus_dir);
  a_r4_released_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> !bus_ad_oe);
  a_r3_ale_not_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> bus_ds_n);
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ale) |-> (bus_ad_oe && $stable(bus_ad_o)));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r5_pulse_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(bus_ds_n));
  a_r5_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ds_n) |-> (low_run_q >= LW'(MIN_DSL)));
  a_r2_ready_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_ds_n && !bus_ale));

endmodule

bind mbus_rd_seq mbus_rd_seq_chk #(.AW(AW), .DW(DW), .MIN_DSL(N_DSL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .bus_ad_o  (bus_ad_o),
  .bus_ad_oe (bus_ad_oe),
  .bus_ale   (bus_ale),
  .bus_cs_n  (bus_cs_n),
  .bus_ds_n  (bus_ds_n),
  .bus_dir   (bus_dir)
);

// File: tb/sim_mbus_rd_seq.sv
`timescale 1ns/1ps
module sim_mbus_rd_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_arb = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_addr = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] bus_ad_o;
  logic        bus_ad_oe;
  logic [15:0] bus_ad_i;
  logic        bus_ale, bus_cs_n, bus_ds_n, bus_dir;

  always #2 clk = ~clk;

  mbus_rd_seq u0 (
    .clk(clk), .rst_n(rst_n), .slow_arb(slow_arb),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
    .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_ds_n(bus_ds_n), .bus_dir(bus_dir)
  );

  // Target model: word valid 10 cycles into the strobe, inverted before.
  logic [15:0] dev_word = '0;
  int          dev_cnt = 0;
  always @(posedge clk) dev_cnt <= bus_ds_n ? 0 : dev_cnt + 1;
  assign bus_ad_i = (!bus_ds_n && dev_cnt >= 10) ? dev_word : ~dev_word;

  // Bus monitor, records the cycle that just ended at each rising edge.
  int cyc = 0, acc_cyc = 0, last_fall = 0, last_rise = 0, ale_start = 0, ale_fall = 0, dir_rise = 0;
  int fall_gap = 0, acc2fall = 0, low_w = 0, ale_w = 0, oe_gap = 0, dir_lead = 0, dir_tail = 0;
  logic [15:0] addr_seen = '0;
  logic prev_ds = 1'b1, prev_ale = 1'b0, prev_oe = 1'b0, prev_dir = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (req_valid && req_ready) acc_cyc = cyc;
    if (!bus_ds_n && prev_ds) begin
      fall_gap = cyc - last_fall; last_fall = cyc; acc2fall = cyc - acc_cyc;
      dir_lead = cyc - dir_rise;
    end
    if (bus_ds_n && !prev_ds) begin low_w = cyc - last_fall; last_rise = cyc; end
    if (bus_ale && !prev_ale) ale_start = cyc;
    if (!bus_ale && prev_ale) begin ale_w = cyc - ale_start; ale_fall = cyc; addr_seen = bus_ad_o; end
    if (!bus_ad_oe && prev_oe && !bus_ale) oe_gap = cyc - ale_fall;
    if (bus_dir && !prev_dir) dir_rise = cyc;
    if (!bus_dir && prev_dir) dir_tail = cyc - last_rise;
    prev_ds = bus_ds_n; prev_ale = bus_ale; prev_oe = bus_ad_oe; prev_dir = bus_dir;
  end

  int checks = 0, fails = 0;
  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  addr;
    logic        slow;
    logic [15:0] word;
    logic [7:0]  gap;   // expected fall-to-fall cycles, 0 = not measured
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 1'b0, 16'h1234, 8'd0},   // first after reset
    '{3'd2, 1'b0, 16'hA5C3, 8'd47},  // R8 data->ptr fast: 15+32
    '{3'd3, 1'b0, 16'h0F0F, 8'd28},  // R9 ptr->ptr natural
    '{3'd1, 1'b1, 16'h8001, 8'd50},  // R7 slow four-period rule
    '{3'd4, 1'b1, 16'h7E57, 8'd50},  // R7 slow
    '{3'd3, 1'b1, 16'hBEEF, 8'd78},  // R8 data->ptr slow: 15+63
    '{3'd4, 1'b0, 16'h55AA, 8'd28},  // R9
    '{3'd0, 1'b0, 16'hFFFF, 8'd28},  // R9 data->non-ptr no extra gap
    '{3'd4, 1'b0, 16'h0000, 8'd28},
    '{3'd2, 1'b1, 16'hC0DE, 8'd78},  // R8 slow
    '{3'd3, 1'b0, 16'h4321, 8'd28}   // R9 ptr->ptr after slow
  };

  task automatic present(input logic [2:0] a, input logic s, input logic [15:0] w);
    req_addr = a; slow_arb = s; dev_word = w; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(!req_ready, "R2 busy during cycle", req_ready, 0);
    chk(rsp_data == w, "R5 read word", rsp_data, w);
    @(negedge clk);
    chk(!rsp_valid, "R5 one-cycle pulse", rsp_valid, 0);
  endtask

  task automatic finish_up;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_cs_n && bus_ds_n && !bus_ale && !bus_ad_oe && !bus_dir && !rsp_valid && req_ready,
        "R1 idle in reset", {bus_cs_n, bus_ds_n, bus_ale, bus_ad_oe, bus_dir, rsp_valid, req_ready}, 7'b1100001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_cs_n && bus_ds_n && !bus_dir && req_ready, "R1 idle after reset",
        {bus_cs_n, bus_ds_n, bus_dir, req_ready}, 4'b1101);

    for (int i = 0; i < NV; i++) begin
      present(VEC[i].addr, VEC[i].slow, VEC[i].word);
      chk(ale_w == 5, "R3 latch-enable width", ale_w, 5);
      chk(addr_seen == {13'd0, VEC[i].addr}, "R3 address on bus", addr_seen, VEC[i].addr);
      chk(oe_gap == 3, "R4 address hold then release", oe_gap, 3);
      chk(low_w == 15, "R5 strobe low width", low_w, 15);
      chk(dir_lead >= 3, "R6 dir leads strobe", dir_lead, 3);
      if (VEC[i].gap != 0)
        chk(fall_gap == int'(VEC[i].gap), "R7/R8/R9 strobe spacing", fall_gap, VEC[i].gap);
      else
        chk(acc2fall == 10, "R9 no-history strobe delay", acc2fall, 10);
    end
    repeat (4) @(negedge clk);
    chk(dir_tail == 3, "R6 dir hold after strobe", dir_tail, 3);
    chk(req_ready && bus_cs_n, "R2 ready again when idle", {req_ready, bus_cs_n}, 2'b11);

    // R10: reset during a data-register strobe, then a pointer read.
    req_addr = 3'd4; slow_arb = 1'b1; dev_word = 16'h9999; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (bus_ds_n) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_ds_n && bus_cs_n && !bus_dir && req_ready, "R10 reset aborts cycle",
        {bus_ds_n, bus_cs_n, bus_dir, req_ready}, 4'b1101);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    present(3'd2, 1'b1, 16'h2468);
    chk(acc2fall == 10, "R10 history cleared by reset", acc2fall, 10);

    finish_up();
  end

endmodule